// File: doc/BRIEF.md
# Sparse-Space PCI Address Generator

This block turns a noncached 40-bit CPU physical address into a 32-bit PCI address for the sparse memory and sparse I/O windows. In sparse space, the low CPU address bits 7:3 do not carry address. They carry the transfer size, the byte offset within a longword, and PCI address bit 2. As a result, each PCI byte occupies 32 bytes of CPU address space.

The block decodes which of five sparse windows the address falls in: three memory windows and two I/O windows. Depending on the window, the high PCI address bits come from a relocation register or from the CPU address. The block also produces active-low byte enables and a transfer length.

Requests enter through a valid/ready handshake and leave through a registered valid/ready output stage. An illegal encoding, or an address outside every sparse window, produces a one-cycle error pulse instead of an output request. The block never generates a request that the CPU did not issue, so no read-ahead beat is ever produced.

Top module: `sparse_addr_gen`

## Requirements
- R1: CPU address bits 39:32 select the window and its region code. 0x80..0x83 is memory window 1 (code 1). 0x84 is memory window 2 (code 2). 0x85 is split by CPU bits 31:30: values 00 and 01 give memory window 3 (code 3), 10 gives I/O window A (code 4), and 11 gives I/O window B (code 5).
- R2: CPU bits 30:8 drive PCI bits 25:3 in memory windows 1 to 3. CPU bits 29:8 drive PCI bits 24:3 in both I/O windows.
- R3: The upper PCI bits depend on the window:
  - Window 1: PCI 31:29 = reloc_i[31:29] and PCI 28:26 = CPU 33:31.
  - Window 2: PCI 31:27 = reloc_i[28:24] and PCI 26 = CPU 31.
  - Window 3: PCI 31:26 = reloc_i[23:18].
  - I/O window B: PCI 31:25 = reloc_i[6:0].
  - I/O window A: PCI 31:25 = 0, whatever reloc_i holds.
- R4: PCI bit 2 equals CPU bit 7. PCI bits 1:0 equal the byte offset (CPU bits 6:5) in the I/O windows and are 00 in the memory windows.
- R5: CPU bits 4:3 encode the size: 00 is one byte, 01 is two bytes, 10 is three bytes, 11 is four bytes. The length output is 1 to 4 accordingly.
- R6: Active-low byte enable k is 0 exactly when offset <= k < offset + length.
- R7: When offset + length exceeds 4, the request raises the illegal flag and produces no output valid.
- R8: An address outside every window (bit 39 clear, or bits 39:32 above 0x85) gives region code 0, raises the illegal flag and produces no output valid.
- R9: Results appear registered, on the cycle after the input handshake. in_ready_o is high whenever the output stage is empty or is being drained.
- R10: While out_valid_o is high and out_ready_i is low, every output holds its value and no new request is taken.
- R11: The illegal flag lasts exactly one cycle per rejected request.
- R12: The write flag is carried to the output unchanged with its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request accepted when high with in_valid_i |
| cpu_addr_i | input | 40 | CPU physical address |
| write_i | input | 1 | 1 for write, 0 for read |
| reloc_i | input | 32 | Relocation register contents |
| out_valid_o | output | 1 | PCI request valid |
| out_ready_i | input | 1 | Downstream accepts the PCI request |
| pci_addr_o | output | 32 | PCI address |
| byte_en_no | output | 4 | Byte enables, active low |
| len_o | output | 3 | Transfer length in bytes |
| region_o | output | 3 | Region code |
| write_o | output | 1 | Write flag of the request |
| illegal_o | output | 1 | One-cycle illegal-encoding pulse |

## Verification
The bench builds the block with its package defaults: a 40-bit CPU address, a 32-bit PCI address and a 32-bit relocation register. These widths make all five windows and the unmapped space reachable from random stimulus. Random addresses are drawn per window, each with random size, offset and relocation contents, so that legal encodings and boundary-crossing encodings both occur. Directed cases cover every size and offset pair, the window edges, unmapped addresses with bit 39 set and with bit 39 clear, and a stall of the output stage while a second request waits.

// File: rtl/sparse_addr_pkg.sv
package sparse_addr_pkg;
  localparam int CPU_AW = 40;
  localparam int PCI_AW = 32;
  localparam int RELOC_W = 32;
  localparam int LANES = 4;
  localparam int LEN_W = $clog2(LANES) + 1;
  localparam int HI_W = PCI_AW - 3;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_MEM1 = 3'd1,
    RG_MEM2 = 3'd2,
    RG_MEM3 = 3'd3,
    RG_IOA  = 3'd4,
    RG_IOB  = 3'd5
  } region_e;
endpackage

// File: rtl/sparse_region_dec.sv
module sparse_region_dec
  import sparse_addr_pkg::*;
(
  input  logic [CPU_AW-1:0]  addr_i,
  input  logic [RELOC_W-1:0] reloc_i,
  output region_e            region_o,
  output logic [HI_W-1:0]    pci_hi_o,
  output logic               is_io_o
);
  always_comb begin
    region_o = RG_NONE;
    pci_hi_o = '0;
    if (addr_i[39:35] == 5'b10000) begin
      if (!addr_i[34]) begin
        region_o = RG_MEM1;
        pci_hi_o = {reloc_i[31:29], addr_i[33:8]};
      end else if (addr_i[33:32] == 2'b00) begin
        region_o = RG_MEM2;
        pci_hi_o = {reloc_i[28:24], addr_i[31:8]};
      end else if (addr_i[33:32] == 2'b01) begin
        if (!addr_i[31]) begin
          region_o = RG_MEM3;
          pci_hi_o = {reloc_i[23:18], addr_i[30:8]};
        end else if (!addr_i[30]) begin
          region_o = RG_IOA;
          pci_hi_o = {7'd0, addr_i[29:8]};
        end else begin
          region_o = RG_IOB;
          pci_hi_o = {reloc_i[6:0], addr_i[29:8]};
        end
      end
    end
    is_io_o = (region_o == RG_IOA) || (region_o == RG_IOB);
  end
endmodule

// File: rtl/sparse_lane_enc.sv
module sparse_lane_enc
  import sparse_addr_pkg::*;
(
  input  logic [4:0]       code_i,   // CPU bits 7:3
  input  logic             is_io_i,
  output logic [LANES-1:0] be_no,
  output logic [LEN_W-1:0] len_o,
  output logic [2:0]       low_o,
  output logic             legal_o
);
  logic [1:0] size;
  logic [1:0] off;
  logic [2:0] last;

  assign size    = code_i[1:0];
  assign off     = code_i[3:2];
  assign last    = {1'b0, off} + {1'b0, size};
  assign legal_o = (last <= 3'd3);
  assign len_o   = LEN_W'({1'b0, size}) + LEN_W'(1);
  assign low_o   = {code_i[4], is_io_i ? off : 2'b00};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign be_no[k] = !((3'(k) >= {1'b0, off}) && (3'(k) <= last));
  end
endmodule

// File: rtl/sparse_addr_gen.sv
module sparse_addr_gen
  import sparse_addr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [CPU_AW-1:0]  cpu_addr_i,
  input  logic               write_i,
  input  logic [RELOC_W-1:0] reloc_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [PCI_AW-1:0]  pci_addr_o,
  output logic [LANES-1:0]   byte_en_no,
  output logic [LEN_W-1:0]   len_o,
  output logic [2:0]         region_o,
  output logic               write_o,
  output logic               illegal_o
);
  region_e          region_d;
  logic [HI_W-1:0]  hi_d;
  logic             is_io_d;
  logic [LANES-1:0] be_d;
  logic [LEN_W-1:0] len_d;
  logic [2:0]       low_d;
  logic             legal_d;
  logic             accept;
  logic             good_d;

  sparse_region_dec u_dec (
    .addr_i  (cpu_addr_i),
    .reloc_i (reloc_i),
    .region_o(region_d),
    .pci_hi_o(hi_d),
    .is_io_o (is_io_d)
  );

  sparse_lane_enc u_enc (
    .code_i (cpu_addr_i[7:3]),
    .is_io_i(is_io_d),
    .be_no  (be_d),
    .len_o  (len_d),
    .low_o  (low_d),
    .legal_o(legal_d)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;
  assign good_d     = legal_d && (region_d != RG_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
      pci_addr_o  <= '0;
      byte_en_no  <= '1;
      len_o       <= '0;
      region_o    <= RG_NONE;
      write_o     <= 1'b0;
    end else begin
      illegal_o <= 1'b0;
      if (accept) begin
        out_valid_o <= good_d;
        illegal_o   <= !good_d;
        pci_addr_o  <= {hi_d, low_d};
        byte_en_no  <= be_d;
        len_o       <= len_d;
        region_o    <= region_d;
        write_o     <= write_i;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(pci_addr_o)
      && $stable(byte_en_no) && $stable(len_o) && $stable(write_o));

  assert_illegal_novalid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !out_valid_o);

  assert_be_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($countones(~byte_en_no) == int'(len_o)));

  assert_region_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (region_o != RG_NONE) && (region_o <= RG_IOB));

  assert_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o && !in_valid_i |=> !illegal_o);

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i && (!out_valid_o || out_ready_i) |=> !out_valid_o && !illegal_o);
endmodule

// File: tb/sparse_addr_gen_tb.sv
module sparse_addr_gen_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [39:0] cpu_addr = '0;
  logic        wr = 0;
  logic [31:0] reloc = '0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [31:0] pci_addr;
  logic [3:0]  be_n;
  logic [2:0]  len;
  logic [2:0]  region;
  logic        wr_o;
  logic        illegal;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sparse_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .cpu_addr_i(cpu_addr), .write_i(wr), .reloc_i(reloc),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .pci_addr_o(pci_addr),
    .byte_en_no(be_n), .len_o(len), .region_o(region), .write_o(wr_o),
    .illegal_o(illegal)
  );

  typedef struct packed {
    logic [2:0]  rg;
    logic [31:0] pa;
    logic [3:0]  be;
    logic [2:0]  ln;
    logic        ok;
  } exp_t;

  function automatic exp_t model(logic [39:0] a, logic [31:0] r);
    exp_t e;
    int off, n;
    e = '0;
    if (a[39:32] inside {8'h80, 8'h81, 8'h82, 8'h83}) begin
      e.rg = 1; e.pa = {r[31:29], a[33:5]};
    end else if (a[39:32] == 8'h84) begin
      e.rg = 2; e.pa = {r[28:24], a[31:5]};
    end else if (a[39:32] == 8'h85 && !a[31]) begin
      e.rg = 3; e.pa = {r[23:18], a[30:5]};
    end else if (a[39:32] == 8'h85 && a[31:30] == 2'b10) begin
      e.rg = 4; e.pa = {7'd0, a[29:5]};
    end else if (a[39:32] == 8'h85) begin
      e.rg = 5; e.pa = {r[6:0], a[29:5]};
    end
    if (e.rg inside {3'd1, 3'd2, 3'd3}) e.pa[1:0] = 2'b00;
    off = int'(a[6:5]);
    n = int'(a[4:3]) + 1;
    e.ln = 3'(n);
    for (int k = 0; k < 4; k++) e.be[k] = !(k >= off && k < off + n);
    e.ok = (off + n <= 4) && (e.rg != 0);
    return e;
  endfunction

  task automatic chk(input bit c, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare outputs with the model of address a (called at a negedge)
  task automatic compare(input logic [39:0] a, input logic w);
    exp_t e;
    e = model(a, reloc);
    if (e.ok) begin
      chk(out_valid && !illegal, "R9 valid", {out_valid, illegal}, 2'b10);
      chk(region == e.rg, "R1 region", region, e.rg);
      chk(pci_addr == e.pa, "R2 R3 R4 pci_addr", pci_addr, e.pa);
      chk(len == e.ln, "R5 len", len, e.ln);
      chk(be_n == e.be, "R6 byte enables", be_n, e.be);
      chk(wr_o == w, "R12 write", wr_o, w);
    end else begin
      chk(!out_valid && illegal, (e.rg == 0) ? "R8 unmapped" : "R7 crossing",
          {out_valid, illegal}, 2'b01);
      chk(region == e.rg, "R8 region code", region, e.rg);
    end
  endtask

  task automatic send(input logic [39:0] a, input logic w);
    @(negedge clk);
    cpu_addr = a; wr = w; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    compare(a, w);
  endtask

  function automatic logic [39:0] gen(int cls);
    logic [63:0] rv;
    rv = {$urandom, $urandom};
    case (cls)
      0: return {6'b100000, rv[33:0]};
      1: return {8'h84, rv[31:0]};
      2: return {8'h85, 1'b0, rv[30:0]};
      3: return {8'h85, 2'b10, rv[29:0]};
      4: return {8'h85, 2'b11, rv[29:0]};
      5: return {1'b0, rv[38:0]};
      default: return {8'h86 + 8'(rv[40:36]), rv[31:0]};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!out_valid && !illegal && in_ready, "R9 reset state", {out_valid, illegal, in_ready}, 3'b001);
    rst_n = 1;
    reloc = 32'hA5C3_0F5A;

    // every size/offset pair in memory and I/O windows (R4 R5 R6 R7)
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++) begin
        send({8'h81, 24'h12_3456, 1'b1, 2'(o), 2'(s), 3'b000}, 1'b0);
        send({8'h85, 2'b10, 22'h2A_AAAA, 1'b0, 2'(o), 2'(s), 3'b000}, 1'b1);
      end

    // window edges (R1 R2 R3)
    send(40'h80_0000_0000, 0);
    send(40'h83_FFFF_FF80, 1);
    send(40'h84_0000_0000, 0);
    send(40'h84_FFFF_FF80, 1);
    send(40'h85_7FFF_FF80, 0);
    send(40'h85_8000_0000, 0);
    send(40'h85_BFFF_FF80, 1);
    send(40'h85_C000_0000, 0);
    // I/O window A ignores reloc (R3)
    reloc = 32'hFFFF_FFFF;
    send(40'h85_8123_4560, 0);
    chk(pci_addr[31:25] == 7'd0, "R3 window A not relocated", pci_addr, 0);
    // unmapped (R8)
    send(40'h86_0000_0000, 0);
    send(40'h00_1234_5600, 0);
    send(40'h7F_FFFF_FF00, 1);

    // illegal pulse lasts one cycle (R11)
    send(40'h80_0000_0078, 0);
    @(negedge clk);
    chk(!illegal && !out_valid, "R11 pulse one cycle", illegal, 0);

    // backpressure (R10)
    begin
      logic [39:0] a1, a2;
      logic [31:0] held;
      a1 = 40'h84_1357_9B00;
      a2 = 40'h81_0246_8A08;
      send(a1, 1);
      out_ready = 0;
      held = pci_addr;
      cpu_addr = a2; wr = 0; in_valid = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid && !in_ready && pci_addr == held && wr_o == 1,
          "R10 hold under stall", pci_addr, held);
      out_ready = 1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 0;
      compare(a2, 0);
      @(negedge clk);
      chk(!out_valid, "R9 drained", out_valid, 0);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      reloc = $urandom;
      out_ready = 1;
      send(gen(int'($urandom_range(0, 6))), 1'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule